// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This unit holds the hazard logic of an in-order, five-stage load/store pipeline (fetch, decode, execute, memory, write-back). Each cycle it looks at the two source register indices of the instruction in decode. It compares them against the destination indices of the older instructions now in execute and memory. From that comparison it decides four things: which bypass path each operand must use when the instruction reaches execute, whether decode must wait, whether a bubble goes into execute, and whether the wrong-path fetch must be discarded.

The operand selects are worked out one stage early and registered, so the instruction arrives in execute with its multiplexer selects already settled. Branches are resolved in decode under a predict-not-taken policy. The datapath compares the branch operands there and reports the result on `br_taken`. A taken branch discards the single instruction already fetched. A branch whose operand is not yet available waits in decode until it is. The register file writes early in a cycle and reads late in it, so a producer in write-back never needs a bypass path.

Each cycle the unit decides on one of four named actions. RUN lets everything advance. LOAD_STALL holds decode because a load in execute feeds it. BRANCH_STALL holds a branch in decode whose operand is still being computed. REDIRECT discards the fetched instruction after a taken branch. These actions are combinational. The only state is the registered pair of operand selects, which returns to the register-file path on reset.

Top module: `hazard_unit`

## Requirements
- R1: After reset both operand selects `fwd_a_sel` and `fwd_b_sel` read 0 (register file path). With no valid instruction present, `pc_hold`, `ifid_hold`, `idex_bubble`, `ifid_flush`, `br_fwd_a` and `br_fwd_b` are all 0.
- R2: A valid, writing instruction in execute whose destination equals a decode source makes that operand's select read 1 (execute/memory pipeline register) one clock later. Select encoding: 0 = register file, 1 = execute/memory register, 2 = memory/write-back register.
- R3: A valid, writing instruction in memory whose destination equals a decode source makes that operand's select read 2 one clock later.
- R4: When the instructions in execute and memory both write a decode source, the nearer one wins and the select reads 1.
- R5: A producer that writes register 0, is invalid, or has its write-enable low never causes a forward, a stall or a branch bypass. A decode slot with `id_valid` low never stalls and gets selects of 0.
- R6: A load in execute whose destination is a decode source raises `pc_hold`, `ifid_hold` and `idex_bubble` for that cycle, and both selects read 0 one clock later. In the next cycle the load is in memory, no stall is raised, and the matching select reads 2 one clock later.
- R7: A branch in decode with a source written by any instruction in execute raises the three stall controls for that cycle, and both selects read 0 one clock later.
- R8: A branch in decode with a source written by a load in memory stalls. When the source is written by a non-load in memory, the branch does not stall and `br_fwd_a` or `br_fwd_b` (the memory-stage bypass into the branch comparator) is 1 for the matching operand.
- R9: A valid branch in decode with `br_taken` high and no stall raises `ifid_flush` for that cycle and nothing else. `ifid_flush` stays 0 when the branch is not taken and when the decode instruction is not a branch.
- R10: While a branch is stalled, `br_taken` is ignored: `ifid_flush` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs1 | input | REG_IDX_W | First source index in decode |
| id_rs2 | input | REG_IDX_W | Second source index in decode |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| br_taken | input | 1 | Branch comparator outcome in decode |
| ex_valid | input | 1 | Execute slot valid |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_rd | input | REG_IDX_W | Execute destination index |
| mem_valid | input | 1 | Memory slot valid |
| mem_we | input | 1 | Memory instruction writes a register |
| mem_is_load | input | 1 | Memory instruction is a load |
| mem_rd | input | REG_IDX_W | Memory destination index |
| fwd_a_sel | output | 2 | Registered bypass select, first execute operand |
| fwd_b_sel | output | 2 | Registered bypass select, second execute operand |
| br_fwd_a | output | 1 | Bypass memory result to first branch operand |
| br_fwd_b | output | 1 | Bypass memory result to second branch operand |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load a bubble (valid=0) into execute |
| ifid_flush | output | 1 | Clear the fetch/decode valid bit at the next edge |

## Verification
The selects are the only registered state. A corrupted or wrongly prioritised select shows on `fwd_a_sel`/`fwd_b_sel` exactly one clock after the decode inputs that caused it, so the scoreboard compares each stimulus item against the selects one edge later. A wrong action choice (stall instead of redirect, or a missed load-use case) shows in the same cycle on the hold, bubble and flush pins. It also shows one clock later as selects that should have been cleared to 0 by the bubble.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Source of an execute-stage operand
    typedef enum logic [1:0] {
        SRC_FILE  = 2'd0,
        SRC_EXMEM = 2'd1,
        SRC_MEMWB = 2'd2
    } fwd_src_t;

    // Per-cycle hazard action
    typedef enum logic [1:0] {
        ACT_RUN          = 2'd0,
        ACT_LOAD_STALL   = 2'd1,
        ACT_BRANCH_STALL = 2'd2,
        ACT_REDIRECT     = 2'd3
    } hz_act_t;

endpackage

// File: rtl/hz_match.sv
module hz_match #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic             prod_valid,
    input  logic             prod_we,
    input  logic [IDX_W-1:0] prod_rd,
    output logic             hit
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    // Register 0 is hard-wired, so it is never a real producer
    always_comb begin
        hit = prod_valid && prod_we && (prod_rd != ZERO_IDX) && (prod_rd == src_idx);
    end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic               id_valid,
    input  logic               id_is_branch,
    input  logic               br_taken,
    input  logic               ex_is_load,
    input  logic               mem_is_load,
    input  logic [NUM_SRC-1:0] hit_ex,
    input  logic [NUM_SRC-1:0] hit_mem,
    output hz_act_t            act,
    output logic               pc_hold,
    output logic               ifid_hold,
    output logic               idex_bubble,
    output logic               ifid_flush,
    output logic [NUM_SRC-1:0] br_fwd
);
    logic any_ex;
    logic any_mem;
    logic load_use;
    logic br_wait;

    always_comb begin
        any_ex   = |hit_ex;
        any_mem  = |hit_mem;
        load_use = id_valid && ex_is_load && any_ex;
        // Branch operands are compared in decode: an execute result is
        // too late, and a memory-stage load has no data yet
        br_wait  = id_valid && id_is_branch &&
                   (any_ex || (mem_is_load && any_mem));
    end

    // Action selection, nearest hazard first
    always_comb begin
        if (load_use) begin
            act = ACT_LOAD_STALL;
        end else if (br_wait) begin
            act = ACT_BRANCH_STALL;
        end else if (id_valid && id_is_branch && br_taken) begin
            act = ACT_REDIRECT;
        end else begin
            act = ACT_RUN;
        end
    end

    // Output decode per action
    always_comb begin
        pc_hold     = 1'b0;
        ifid_hold   = 1'b0;
        idex_bubble = 1'b0;
        ifid_flush  = 1'b0;
        br_fwd      = '0;
        unique case (act)
            ACT_LOAD_STALL, ACT_BRANCH_STALL: begin
                pc_hold     = 1'b1;
                ifid_hold   = 1'b1;
                idex_bubble = 1'b1;
            end
            ACT_REDIRECT: begin
                ifid_flush = 1'b1;
                br_fwd     = hit_mem;
            end
            ACT_RUN: begin
                if (id_valid && id_is_branch) begin
                    br_fwd = hit_mem;
                end
            end
            default: begin
                pc_hold = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hz_fwd_reg.sv
module hz_fwd_reg
    import hz_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               id_valid,
    input  logic               bubble,
    input  logic [NUM_SRC-1:0] hit_ex,
    input  logic [NUM_SRC-1:0] hit_mem,
    output fwd_src_t           sel_q [NUM_SRC]
);
    fwd_src_t sel_d [NUM_SRC];

    // Next select: the execute producer moves to ex/mem, the memory
    // producer moves to mem/wb by the time this instruction executes
    generate
        for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_next
            always_comb begin
                if (!id_valid || bubble) begin
                    sel_d[gi] = SRC_FILE;
                end else if (hit_ex[gi]) begin
                    sel_d[gi] = SRC_EXMEM;
                end else if (hit_mem[gi]) begin
                    sel_d[gi] = SRC_MEMWB;
                end else begin
                    sel_d[gi] = SRC_FILE;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sel_q[gi] <= SRC_FILE;
                end else begin
                    sel_q[gi] <= sel_d[gi];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hz_pkg::*;
#(
    parameter int REG_IDX_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 id_valid,
    input  logic [REG_IDX_W-1:0] id_rs1,
    input  logic [REG_IDX_W-1:0] id_rs2,
    input  logic                 id_is_branch,
    input  logic                 br_taken,
    input  logic                 ex_valid,
    input  logic                 ex_we,
    input  logic                 ex_is_load,
    input  logic [REG_IDX_W-1:0] ex_rd,
    input  logic                 mem_valid,
    input  logic                 mem_we,
    input  logic                 mem_is_load,
    input  logic [REG_IDX_W-1:0] mem_rd,
    output logic [1:0]           fwd_a_sel,
    output logic [1:0]           fwd_b_sel,
    output logic                 br_fwd_a,
    output logic                 br_fwd_b,
    output logic                 pc_hold,
    output logic                 ifid_hold,
    output logic                 idex_bubble,
    output logic                 ifid_flush
);
    localparam int NUM_SRC = 2;

    logic [REG_IDX_W-1:0] src_idx [NUM_SRC];
    logic [NUM_SRC-1:0]   hit_ex;
    logic [NUM_SRC-1:0]   hit_mem;
    logic [NUM_SRC-1:0]   br_fwd;
    hz_act_t              act;
    fwd_src_t             sel_q [NUM_SRC];

    always_comb begin
        src_idx[0] = id_rs1;
        src_idx[1] = id_rs2;
    end

    generate
        for (genvar gs = 0; gs < NUM_SRC; gs++) begin : g_src
            hz_match #(.IDX_W(REG_IDX_W)) u_match_ex (
                .src_idx    (src_idx[gs]),
                .prod_valid (ex_valid),
                .prod_we    (ex_we),
                .prod_rd    (ex_rd),
                .hit        (hit_ex[gs])
            );
            hz_match #(.IDX_W(REG_IDX_W)) u_match_mem (
                .src_idx    (src_idx[gs]),
                .prod_valid (mem_valid),
                .prod_we    (mem_we),
                .prod_rd    (mem_rd),
                .hit        (hit_mem[gs])
            );
        end
    endgenerate

    hz_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
        .id_valid     (id_valid),
        .id_is_branch (id_is_branch),
        .br_taken     (br_taken),
        .ex_is_load   (ex_is_load),
        .mem_is_load  (mem_is_load),
        .hit_ex       (hit_ex),
        .hit_mem      (hit_mem),
        .act          (act),
        .pc_hold      (pc_hold),
        .ifid_hold    (ifid_hold),
        .idex_bubble  (idex_bubble),
        .ifid_flush   (ifid_flush),
        .br_fwd       (br_fwd)
    );

    hz_fwd_reg #(.NUM_SRC(NUM_SRC)) u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .id_valid (id_valid),
        .bubble   (idex_bubble),
        .hit_ex   (hit_ex),
        .hit_mem  (hit_mem),
        .sel_q    (sel_q)
    );

    always_comb begin
        fwd_a_sel = sel_q[0];
        fwd_b_sel = sel_q[1];
        br_fwd_a  = br_fwd[0];
        br_fwd_b  = br_fwd[1];
    end

    // act is observed only through the decoded controls
    logic unused_act;
    always_comb unused_act = ^act;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
    parameter int REG_IDX_W = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 id_valid,
    input logic [REG_IDX_W-1:0] id_rs1,
    input logic [REG_IDX_W-1:0] id_rs2,
    input logic                 id_is_branch,
    input logic                 br_taken,
    input logic                 ex_valid,
    input logic                 ex_we,
    input logic                 ex_is_load,
    input logic [REG_IDX_W-1:0] ex_rd,
    input logic                 mem_valid,
    input logic [REG_IDX_W-1:0] mem_rd,
    input logic [1:0]           fwd_a_sel,
    input logic [1:0]           fwd_b_sel,
    input logic                 br_fwd_a,
    input logic                 br_fwd_b,
    input logic                 pc_hold,
    input logic                 ifid_hold,
    input logic                 idex_bubble,
    input logic                 ifid_flush
);
    localparam logic [REG_IDX_W-1:0] Z = '0;

    // R1: selects leave reset on the register-file path
    assert_reset_sel_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (fwd_a_sel == 2'd0 && fwd_b_sel == 2'd0));

    // R2 / R4: nearest producer wins for operand A
    assert_near_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && !pc_hold && ex_valid && ex_we && ex_rd != Z && ex_rd == id_rs1)
        |=> fwd_a_sel == 2'd1);

    // R5: register 0 producers never forward nor stall
    assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == Z && mem_rd == Z)
        |-> (!pc_hold && !br_fwd_a && !br_fwd_b));
    assert_zero_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == Z && mem_rd == Z) |=> (fwd_a_sel == 2'd0 && fwd_b_sel == 2'd0));

    // R6: load-use raises all three stall controls
    assert_load_use_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && ex_valid && ex_we && ex_is_load && ex_rd != Z &&
         (ex_rd == id_rs1 || ex_rd == id_rs2))
        |-> (pc_hold && ifid_hold && idex_bubble));

    // R6 / R7: a stalled cycle sends a bubble with file selects
    assert_stall_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> (fwd_a_sel == 2'd0 && fwd_b_sel == 2'd0));
    assert_stall_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_hold == ifid_hold) && (pc_hold == idex_bubble));

    // R9 / R10: flush only for an unstalled taken branch
    assert_flush_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> (id_valid && id_is_branch && br_taken));
    assert_flush_vs_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ifid_flush && pc_hold));

    // R8: branch bypass only for a branch
    assert_brfwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_fwd_a || br_fwd_b) |-> (id_valid && id_is_branch && mem_valid));
endmodule

bind hazard_unit hazard_unit_chk #(.REG_IDX_W(REG_IDX_W)) u_hazard_unit_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_valid     (id_valid),
    .id_rs1       (id_rs1),
    .id_rs2       (id_rs2),
    .id_is_branch (id_is_branch),
    .br_taken     (br_taken),
    .ex_valid     (ex_valid),
    .ex_we        (ex_we),
    .ex_is_load   (ex_is_load),
    .ex_rd        (ex_rd),
    .mem_valid    (mem_valid),
    .mem_rd       (mem_rd),
    .fwd_a_sel    (fwd_a_sel),
    .fwd_b_sel    (fwd_b_sel),
    .br_fwd_a     (br_fwd_a),
    .br_fwd_b     (br_fwd_b),
    .pc_hold      (pc_hold),
    .ifid_hold    (ifid_hold),
    .idex_bubble  (idex_bubble),
    .ifid_flush   (ifid_flush)
);

// File: tb/test_hazard_unit.sv
module test_hazard_unit;

    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         id_valid = 1'b0;
    logic [W-1:0] id_rs1 = '0;
    logic [W-1:0] id_rs2 = '0;
    logic         id_is_branch = 1'b0;
    logic         br_taken = 1'b0;
    logic         ex_valid = 1'b0;
    logic         ex_we = 1'b0;
    logic         ex_is_load = 1'b0;
    logic [W-1:0] ex_rd = '0;
    logic         mem_valid = 1'b0;
    logic         mem_we = 1'b0;
    logic         mem_is_load = 1'b0;
    logic [W-1:0] mem_rd = '0;
    logic [1:0]   fwd_a_sel;
    logic [1:0]   fwd_b_sel;
    logic         br_fwd_a;
    logic         br_fwd_b;
    logic         pc_hold;
    logic         ifid_hold;
    logic         idex_bubble;
    logic         ifid_flush;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hazard_unit #(.REG_IDX_W(W)) i_hazard_unit (.*);

    typedef struct {
        string    tag;
        logic     stall;
        logic     flush;
        logic     bfa;
        logic     bfb;
        logic [1:0] sa;
        logic [1:0] sb;
    } exp_t;

    exp_t q[$];

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stage contents and queue the expectations
    task automatic step(string tag,
                        logic iv, logic [W-1:0] r1, logic [W-1:0] r2, logic br, logic tk,
                        logic ev, logic ew, logic el, logic [W-1:0] erd,
                        logic mv, logic mw, logic ml, logic [W-1:0] mrd,
                        logic xs, logic xf, logic xa, logic xb,
                        logic [1:0] sa, logic [1:0] sb);
        exp_t e;
        @(negedge clk);
        id_valid = iv; id_rs1 = r1; id_rs2 = r2; id_is_branch = br; br_taken = tk;
        ex_valid = ev; ex_we = ew; ex_is_load = el; ex_rd = erd;
        mem_valid = mv; mem_we = mw; mem_is_load = ml; mem_rd = mrd;
        e.tag = tag; e.stall = xs; e.flush = xf; e.bfa = xa; e.bfb = xb;
        e.sa = sa; e.sb = sb;
        q.push_back(e);
    endtask

    // Monitor: controls checked in the same cycle, selects one edge later
    initial begin
        exp_t prev;
        bit   have_prev = 1'b0;
        forever begin
            @(negedge clk);
            #2;
            if (have_prev) begin
                chk(prev.tag, "fwd_a_sel", fwd_a_sel, prev.sa);
                chk(prev.tag, "fwd_b_sel", fwd_b_sel, prev.sb);
            end
            have_prev = 1'b0;
            if (q.size() > 0) begin
                prev = q.pop_front();
                have_prev = 1'b1;
                chk(prev.tag, "pc_hold", pc_hold, prev.stall);
                chk(prev.tag, "ifid_hold", ifid_hold, prev.stall);
                chk(prev.tag, "idex_bubble", idex_bubble, prev.stall);
                chk(prev.tag, "ifid_flush", ifid_flush, prev.flush);
                chk(prev.tag, "br_fwd_a", br_fwd_a, prev.bfa);
                chk(prev.tag, "br_fwd_b", br_fwd_b, prev.bfb);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "fwd_a_sel", fwd_a_sel, 0);
        chk("R1", "fwd_b_sel", fwd_b_sel, 0);
        step("R1", 0,0,0,0,0, 0,0,0,0, 0,0,0,0, 0,0,0,0, 0,0);
        // R2: execute producer -> select 1
        step("R2", 1,3,4,0,0, 1,1,0,3, 0,0,0,0, 0,0,0,0, 1,0);
        // R3: memory producer -> select 2
        step("R3", 1,6,7,0,0, 0,0,0,0, 1,1,0,7, 0,0,0,0, 0,2);
        // R4: both stages write the source, nearest wins
        step("R4", 1,5,5,0,0, 1,1,0,5, 1,1,1,5, 0,0,0,0, 1,1);
        // R4: different producers per operand
        step("R4_split", 1,12,13,0,0, 1,1,0,13, 1,1,0,12, 0,0,0,0, 2,1);
        // R5: register 0, write-enable low, invalid producer, invalid decode
        step("R5_zero", 1,0,0,0,0, 1,1,1,0, 1,1,0,0, 0,0,0,0, 0,0);
        step("R5_nowe", 1,6,6,0,0, 1,0,1,6, 1,0,0,6, 0,0,0,0, 0,0);
        step("R5_inval", 1,6,6,0,0, 0,1,1,6, 0,1,0,6, 0,0,0,0, 0,0);
        step("R5_noid", 0,8,8,1,1, 1,1,1,8, 0,0,0,0, 0,0,0,0, 0,0);
        // R6: load-use stall, then release with load in memory
        step("R6_stall", 1,2,8,0,0, 1,1,1,8, 0,0,0,0, 1,0,0,0, 0,0);
        step("R6_go", 1,2,8,0,0, 0,0,0,0, 1,1,1,8, 0,0,0,0, 0,2);
        // R7: branch depends on execute ALU result
        step("R7_stall", 1,9,1,1,1, 1,1,0,9, 0,0,0,0, 1,0,0,0, 0,0);
        step("R8_fwd_a", 1,9,1,1,0, 0,0,0,0, 1,1,0,9, 0,0,1,0, 2,0);
        // R8: branch depends on load in memory, then on ALU in memory
        step("R8_ldstall", 1,1,10,1,0, 0,0,0,0, 1,1,1,10, 1,0,0,0, 0,0);
        step("R8_fwd_b", 1,1,11,1,1, 0,0,0,0, 1,1,0,11, 0,1,0,1, 0,2);
        // R9: taken, not taken, non-branch with taken high
        step("R9_taken", 1,14,15,1,1, 0,0,0,0, 0,0,0,0, 0,1,0,0, 0,0);
        step("R9_nottaken", 1,14,15,1,0, 0,0,0,0, 0,0,0,0, 0,0,0,0, 0,0);
        step("R9_nonbr", 1,14,15,0,1, 0,0,0,0, 0,0,0,0, 0,0,0,0, 0,0);
        // R10: taken flag ignored during a branch stall
        step("R10", 1,16,17,1,1, 1,1,0,17, 0,0,0,0, 1,0,0,0, 0,0);
        step("R1_idle", 0,0,0,0,0, 0,0,0,0, 0,0,0,0, 0,0,0,0, 0,0);
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule